// File: doc/BRIEF.md
# Circular Local-Register Stack with Automatic Spill and Fill

This block is a windowed file of local registers for a processor core. It holds the stack frames of nested procedures in a 64-slot on-chip ring of 32-bit words. The decode logic addresses registers by a 4-bit index relative to the current frame pointer. A call opens a new frame, and the new frame may begin inside the caller's frame. The words they share then carry arguments and results in place.

Sometimes a call would need more slots than the ring holds. In that case the block stalls and copies the oldest on-chip words to memory, one word per handshake, at rising addresses. Sometimes a return exposes caller words that were copied out earlier. In that case the block stalls and reads them back, one word per handshake, from falling addresses. The memory image therefore grows and shrinks like an ordinary stack: the word at absolute stack position p is stored at `MEM_BASE + p`.

The return request carries the caller's frame size and the overlap that was used at the call. Keeping these values is the core's job. The block does not check requests for legality. The core must keep the overlap no larger than either frame's length and must never return below the bottom frame.

Top module: `circ_regstack`

## Requirements
- R1: Every word is 32 bits wide. A read or write with register index i (0..15) accesses physical slot (FP + i) mod 64. The read data follows `rd_idx` combinationally.
- R2: An accepted call with size S and overlap V moves FP to FP + L − V, where L is the caller's length, and sets the length to S. Callee index j < V returns the word the caller saw at index L − V + j.
- R3: Suppose that after a call the on-chip occupancy (top minus bottom) would exceed 64. Then `stall` rises in the next cycle. The block writes exactly the excess count of oldest words to memory, one per `mem_ack`, at strictly rising addresses. The word at absolute stack position p goes to address MEM_BASE + p.
- R4: An accepted return with caller size S and overlap V moves FP to FP − (S − V) and sets the length to S. If the new frame reaches below the oldest on-chip word, `stall` rises in the next cycle. The block then reads the missing words one per `mem_ack`, from strictly falling addresses starting at the spill pointer minus one, and their values are restored.
- R5: A register write presented while `stall` is high has no effect on any word.
- R6: A call or return presented while `stall` is high is ignored. The frame pointer and length do not move.
- R7: While `mem_req` is high and `mem_ack` is low, the next cycle keeps `mem_req`, `mem_addr` and `mem_we` unchanged.
- R8: After reset, `stall` and `mem_req` are low, all words read 0, FP and length are 0, and the spill pointer equals MEM_BASE.
- R9: A call or return that needs no word moved leaves `stall` and `mem_req` low. If call and return are requested together, the call wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_idx | input | 4 | Frame-relative read index |
| rd_data | output | 32 | Word at the read index |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Frame-relative write index |
| wr_data | input | 32 | Word to write |
| call_req | input | 1 | Open a new frame |
| call_size | input | 5 | New frame length, 1..16 |
| call_ovl | input | 5 | Words shared with the caller |
| ret_req | input | 1 | Return to the caller frame |
| ret_size | input | 5 | Caller frame length |
| ret_ovl | input | 5 | Overlap used at the matching call |
| stall | output | 1 | Spill or fill in progress |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Spill data |
| mem_rdata | input | 32 | Fill data, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the current word |

## Verification
The assertions check several properties on every cycle. A pending memory request holds its address and direction (R7). Spill bursts climb and fill bursts descend one address per word (R3, R4). The frame stays frozen while stalled (R6). Whenever the block is idle, the occupancy lies between the frame length and 64. The bench checks the things that depend on data. It tracks every word's value by absolute stack position, so it shows that overlapped registers alias correctly (R2), that spilled data lands at MEM_BASE + p and comes back intact (R3, R4), and that the exact number of words moved matches the arithmetic excess. It also shows that writes and returns poked into a stall leave no trace (R5, R6). Three rounds of deep call chains with different acknowledge rates are used, so the frames wrap the ring several times.

// File: rtl/rstk_pkg.sv
// Shared types for the circular register stack.
// Assumes: nothing beyond IEEE 1800-2017.
package rstk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPILL = 2'd1,
        ST_FILL  = 2'd2
    } rs_state_e;
endpackage

// File: rtl/rs_regfile.sv
// Ring storage: DEPTH words of DW bits, one write port and two
// combinational read ports (frame read and spill source).
// Assumes the write address is in range; all words clear on reset.
module rs_regfile #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [PW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [DEPTH];

    // storage update: clear on reset, else single write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // combinational reads
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/rs_frame_calc.sv
// Computes the frame pointer, length and occupancy after a call or a
// return. Pure combinational arithmetic, modulo the ring size.
// Assumes overlap <= both frame lengths and the counts fit in CW bits.
module rs_frame_calc #(
    parameter int PW = 6,
    parameter int LW = 5,
    parameter int CW = 7
) (
    input  logic          is_call,
    input  logic [PW-1:0] fp,
    input  logic [LW-1:0] flen,
    input  logic [CW-1:0] cnt,
    input  logic [LW-1:0] size,
    input  logic [LW-1:0] ovl,
    output logic [PW-1:0] nfp,
    output logic [LW-1:0] nlen,
    output logic [CW-1:0] ncnt
);
    logic [CW-1:0] fp_w, fl_w, sz_w, ov_w, sum;

    // widen operands so the ring arithmetic wraps after slicing
    always_comb begin
        fp_w = CW'(fp);
        fl_w = CW'(flen);
        sz_w = CW'(size);
        ov_w = CW'(ovl);
        if (is_call) begin
            sum  = fp_w + fl_w - ov_w;
            ncnt = cnt + sz_w - ov_w;
        end else begin
            sum  = fp_w - (sz_w - ov_w);
            ncnt = cnt - (fl_w - ov_w);
        end
        nfp  = sum[PW-1:0];
        nlen = size;
    end
endmodule

// File: rtl/circ_regstack.sv
// Circular local-register stack with automatic spill and fill.
// Frame-relative register port, call/return requests, and a word-wide
// memory port used only while stall is high. The core supplies legal
// sizes and overlaps; call has priority over return.
module circ_regstack
    import rstk_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          DEPTH     = 64,
    parameter int          MAX_FRAME = 16,
    parameter int          AW        = 32,
    parameter int unsigned MEM_BASE  = 32'h0000_1000,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int IDX_W = $clog2(MAX_FRAME),
    localparam int LEN_W = IDX_W + 1,
    localparam int CNT_W = $clog2(DEPTH + MAX_FRAME + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             call_req,
    input  logic [LEN_W-1:0] call_size,
    input  logic [LEN_W-1:0] call_ovl,
    input  logic             ret_req,
    input  logic [LEN_W-1:0] ret_size,
    input  logic [LEN_W-1:0] ret_ovl,
    output logic             stall,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ack
);
    rs_state_e        state;
    logic [PTR_W-1:0] fp, bot, bot_dn;
    logic [LEN_W-1:0] flen;
    logic [CNT_W-1:0] cnt, cnt_inc, cnt_dec;
    logic [AW-1:0]    msp;

    logic [PTR_W-1:0] nfp;
    logic [LEN_W-1:0] nlen;
    logic [CNT_W-1:0] ncnt;
    logic             idle, fill_we, reg_we, rf_we;
    logic [PTR_W-1:0] rf_waddr;
    logic [DW-1:0]    rf_wdata, spill_word;

    // next-frame arithmetic for whichever request is presented
    rs_frame_calc #(.PW(PTR_W), .LW(LEN_W), .CW(CNT_W)) u_calc (
        .is_call (call_req),
        .fp      (fp),
        .flen    (flen),
        .cnt     (cnt),
        .size    (call_req ? call_size : ret_size),
        .ovl     (call_req ? call_ovl  : ret_ovl),
        .nfp     (nfp),
        .nlen    (nlen),
        .ncnt    (ncnt)
    );

    // write-port arbitration: fill data while stalled, else frame writes
    always_comb begin
        idle     = (state == ST_IDLE);
        bot_dn   = bot - PTR_W'(1);
        cnt_inc  = cnt + CNT_W'(1);
        cnt_dec  = cnt - CNT_W'(1);
        fill_we  = (state == ST_FILL) && mem_ack;
        reg_we   = wr_en && idle;
        rf_we    = fill_we || reg_we;
        rf_waddr = fill_we ? bot_dn : fp + PTR_W'(wr_idx);
        rf_wdata = fill_we ? mem_rdata : wr_data;
    end

    rs_regfile #(.DW(DW), .DEPTH(DEPTH)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (fp + PTR_W'(rd_idx)),
        .rdata_a (rd_data),
        .raddr_b (bot),
        .rdata_b (spill_word)
    );

    // frame and spill/fill sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            fp    <= '0;
            flen  <= '0;
            cnt   <= '0;
            bot   <= '0;
            msp   <= AW'(MEM_BASE);
        end else begin
            case (state)
                ST_IDLE: begin
                    if (call_req || ret_req) begin
                        fp   <= nfp;
                        flen <= nlen;
                        cnt  <= ncnt;
                        if (call_req && ncnt > CNT_W'(DEPTH))
                            state <= ST_SPILL;
                        else if (!call_req && ncnt < CNT_W'(nlen))
                            state <= ST_FILL;
                    end
                end
                ST_SPILL: begin
                    if (mem_ack) begin
                        bot <= bot + PTR_W'(1);
                        msp <= msp + AW'(1);
                        cnt <= cnt_dec;
                        if (cnt_dec == CNT_W'(DEPTH)) state <= ST_IDLE;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        bot <= bot_dn;
                        msp <= msp - AW'(1);
                        cnt <= cnt_inc;
                        if (cnt_inc == CNT_W'(flen)) state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // memory port and stall outputs
    assign stall     = !idle;
    assign mem_req   = !idle;
    assign mem_we    = (state == ST_SPILL);
    assign mem_addr  = (state == ST_FILL) ? msp - AW'(1) : msp;
    assign mem_wdata = spill_word;
endmodule

// File: rtl/circ_regstack_chk.sv
// Cycle-level checks for circ_regstack, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module circ_regstack_chk #(
    parameter int DEPTH = 64,
    parameter int PTR_W = 6,
    parameter int LEN_W = 5,
    parameter int CNT_W = 7,
    parameter int AW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [AW-1:0]    mem_addr,
    input logic [PTR_W-1:0] fp,
    input logic [LEN_W-1:0] flen,
    input logic [CNT_W-1:0] cnt
);
    // R7: pending request holds its address and direction
    a_r7_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: spill addresses climb by one within a burst
    a_r3_spill_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=>
        (!mem_req || !mem_we || mem_addr == $past(mem_addr) + AW'(1)));

    // R4: fill addresses fall by one within a burst
    a_r4_fill_descend: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=>
        (!mem_req || mem_we || mem_addr == $past(mem_addr) - AW'(1)));

    // R6: frame does not move while stalled
    a_r6_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(fp) && $stable(flen)));

    // R3/R4: once idle, occupancy fits the ring and covers the frame
    a_r3_r4_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |-> (cnt <= CNT_W'(DEPTH) && cnt >= CNT_W'(flen)));
endmodule

bind circ_regstack circ_regstack_chk #(
    .DEPTH(DEPTH), .PTR_W(PTR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .AW(AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .stall(stall), .mem_req(mem_req),
    .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .fp(fp), .flen(flen), .cnt(cnt)
);

// File: tb/tb_circ_regstack.sv
module tb_circ_regstack;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 32'h0000_1000;
    localparam int NCALL      = 10;

    logic        clk = 0, rst_n = 0;
    logic [3:0]  rd_idx = 0, wr_idx = 0;
    logic [31:0] rd_data, wr_data = 0;
    logic        wr_en = 0, call_req = 0, ret_req = 0;
    logic [4:0]  call_size = 0, call_ovl = 0, ret_size = 0, ret_ovl = 0;
    logic        stall, mem_req, mem_we, mem_ack = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;

    circ_regstack #(.MEM_BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .call_req(call_req), .call_size(call_size), .call_ovl(call_ovl),
        .ret_req(ret_req), .ret_size(ret_size), .ret_ovl(ret_ovl),
        .stall(stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0, fails = 0;
    logic [31:0] lval [0:1023];
    logic [31:0] mem  [0:1023];
    int afp = 0, alen = 0, abot = 0;
    int exp_spill = 0, exp_fill = 0, spill_cnt = 0, fill_cnt = 0;
    int ack_div = 1, cyc = 0;
    int prev_len [0:NCALL-1];
    int used_ovl [0:NCALL-1];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model: acknowledge at a chosen rate, serve fill data
    always @(negedge clk) begin
        cyc++;
        if (mem_req) begin
            mem_ack   <= (cyc % ack_div) == 0;
            mem_rdata <= mem[mem_addr - BASE];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // R3: spilled data and address match the word's stack position
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (mem_we) begin
                check("R3 spill data", mem_wdata, lval[mem_addr - BASE]);
                mem[mem_addr - BASE] = mem_wdata;
                spill_cnt++;
            end else begin
                fill_cnt++;
            end
        end
    end

    task automatic wait_idle();
        while (stall) @(negedge clk);
    endtask

    task automatic rd_check(input int idx, input string req);
        @(negedge clk);
        rd_idx = idx[3:0];
        #1 check(req, rd_data, lval[afp + idx]);
    endtask

    task automatic wr(input int idx, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1; wr_idx = idx[3:0]; wr_data = v;
        @(negedge clk);
        wr_en = 0;
        lval[afp + idx] = v;
    endtask

    task automatic do_call(input int size, input int ovl, input bit poke);
        int nfp, ntop;
        bit sp;
        nfp = afp + alen - ovl;
        ntop = nfp + size;
        sp = (ntop - abot) > 64;
        @(negedge clk);
        call_req = 1; call_size = size[4:0]; call_ovl = ovl[4:0];
        @(negedge clk);
        call_req = 0;
        check(sp ? "R3 stall on overflow" : "R9 no stall on call", {31'd0, stall}, {31'd0, sp});
        if (poke && stall) begin
            wr_en = 1; wr_idx = 0; wr_data = 32'hDEAD_BEEF;
            ret_req = 1; ret_size = 5'd1; ret_ovl = 5'd0;
            @(negedge clk);
            wr_en = 0; ret_req = 0;
        end
        if (sp) begin
            exp_spill += ntop - 64 - abot;
            abot = ntop - 64;
        end
        afp = nfp; alen = size;
        wait_idle();
        if (poke) begin
            for (int i = 0; i < ovl; i++) rd_check(i, i == 0 ? "R5 stalled write ignored" : "R6 stalled return ignored");
        end
    endtask

    task automatic do_ret(input int size, input int ovl);
        int nfp;
        bit fl;
        nfp = afp - (size - ovl);
        fl = nfp < abot;
        @(negedge clk);
        ret_req = 1; ret_size = size[4:0]; ret_ovl = ovl[4:0];
        @(negedge clk);
        ret_req = 0;
        check(fl ? "R4 stall on underflow" : "R9 no stall on return", {31'd0, stall}, {31'd0, fl});
        if (fl) begin
            exp_fill += abot - nfp;
            abot = nfp;
        end
        afp = nfp; alen = size;
        wait_idle();
    endtask

    // watchdog: a hung run is a failed check
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin lval[i] = '0; mem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8: reset state
        check("R8 stall", {31'd0, stall}, 32'd0);
        check("R8 mem_req", {31'd0, mem_req}, 32'd0);
        for (int i = 0; i < 16; i++) rd_check(i, "R8 cleared word");

        // R9: call and return together -> call wins
        @(negedge clk);
        call_req = 1; call_size = 5'd4; call_ovl = 5'd0;
        ret_req = 1; ret_size = 5'd2; ret_ovl = 5'd0;
        @(negedge clk);
        call_req = 0; ret_req = 0;
        afp = 0; alen = 4;
        wr(3, 32'h1234_5678);
        rd_check(3, "R9 call priority");
        do_ret(0, 0);

        for (int r = 0; r < 3; r++) begin
            bit poked = 0;
            ack_div = r + 1;
            spill_cnt = 0; fill_cnt = 0; exp_spill = 0; exp_fill = 0;
            for (int k = 0; k < NCALL; k++) begin
                int size, ovl, nfp;
                bit pk;
                size = 6 + ((k * 7 + r * 3) % 11);
                ovl = (k + r) % 5;
                if (ovl > alen) ovl = alen;
                if (ovl > size) ovl = size;
                nfp = afp + alen - ovl;
                pk = !poked && r == 2 && ovl > 0 && (nfp + size - abot) > 64;
                if (pk) poked = 1;
                prev_len[k] = alen; used_ovl[k] = ovl;
                do_call(size, ovl, pk);
                for (int i = 0; i < ovl; i++) rd_check(i, "R2 overlap alias");
                for (int i = ovl; i < size; i++)
                    wr(i, {r[7:0], 8'hC3, 16'(afp + i)});
                for (int i = 0; i < size; i++) rd_check(i, "R1 frame word");
            end
            check("R3 words spilled", spill_cnt, exp_spill);
            for (int k = NCALL - 1; k >= 0; k--) begin
                do_ret(prev_len[k], used_ovl[k]);
                for (int i = 0; i < alen; i++) rd_check(i, "R4 restored word");
            end
            check("R4 words filled", fill_cnt, exp_fill);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule